// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the block misses that a non-blocking data cache still has outstanding, so that the cache can go on serving hits and further misses while earlier fetches are in flight. Every entry owns one missing block. It records the block address and a short list of the loads and stores waiting on that block. For each waiting access it keeps the access kind, the size format, the offset inside the block and the register it reads or writes. A miss to a block that is not yet tracked takes a fresh entry and starts exactly one memory fetch. A miss to a block that is already being fetched is added to that block's list as a secondary miss, and no new fetch is sent.

When memory returns a fill for a tracked block, the waiting accesses come out on the replay port one per cycle, in the order they arrived. The cache uses them to finish the loads and merge the stores. The entry is freed after the last one. When an entry or a slot that a request needs is not available, the block raises a stall toward the cache pipeline, which holds the request until the stall drops.

Each entry runs a four-state machine. FREE moves to PENDING on allocation. PENDING moves to FILLED when a matching fill arrives. FILLED moves to DRAINING when the replay engine starts on it. DRAINING moves back to FREE as its last slot is replayed. The replay engine has two states. IDLE moves to RUN when at least one entry is FILLED, and it takes the lowest-numbered such entry. RUN moves back to IDLE in the cycle that replays the last slot of that entry.

Top module: `mshr_file`

## Requirements
- R1: After reset all entries are free. `mem_req_valid`, `replay_valid` and `miss_stall` are 0, and the first miss to any block is accepted without stall.
- R2: An accepted miss to an untracked block allocates the lowest-numbered free entry. In the next cycle `mem_req_valid` is 1 for exactly one cycle, with `mem_req_blk` equal to the block address. That entry number later appears on `replay_entry`.
- R3: An accepted miss to a block whose entry is PENDING and has a free slot is stored in that entry's next slot. It produces no memory request.
- R4: A miss to an untracked block while all entries are in use raises `miss_stall` in the same cycle. It produces no memory request and changes no entry.
- R5: A miss to a PENDING block whose entry already holds all slots (4 by default) raises `miss_stall`. It produces no memory request and adds nothing to the replay.
- R6: A miss to a block whose entry is FILLED or DRAINING raises `miss_stall` and produces no memory request.
- R7: A fill sampled at clock edge k makes slot 0 of that entry appear on the replay port after edge k+1. Each further edge presents the next slot in arrival order, until every stored slot has appeared once. The replay port carries `replay_blk`, `replay_is_store` (1 for a store), `replay_fmt`, `replay_off` and `replay_reg`, exactly as they were given with the miss. After the last slot `replay_valid` drops and the entry is free, so a new miss to that block allocates again and requests again.
- R8: A fill whose block matches no PENDING entry has no effect, and no replay follows it.
- R9: A miss that merges in the same cycle a fill for its block is sampled is accepted without stall. It is replayed after the slots that were already stored.
- R10: The slots of one entry are never interleaved with those of another entry. When the engine is idle and several entries are FILLED, the lowest-numbered entry is replayed first, and there is one idle cycle between entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_blk | input | BLK_AW | Block address of the miss |
| miss_is_store | input | 1 | 1 for a store, 0 for a load |
| miss_fmt | input | FMT_W | Access size and format code |
| miss_off | input | OFF_W | Byte offset within the block |
| miss_reg | input | REG_W | Destination register (load) or source register (store) |
| miss_stall | output | 1 | Miss cannot be accepted this cycle |
| mem_req_valid | output | 1 | One-cycle memory fetch request |
| mem_req_blk | output | BLK_AW | Block address to fetch |
| fill_valid | input | 1 | Memory fill returned this cycle |
| fill_blk | input | BLK_AW | Block address of the fill |
| replay_valid | output | 1 | A pending access is being replayed |
| replay_entry | output | EW | Entry number being replayed |
| replay_blk | output | BLK_AW | Block address of the replayed access |
| replay_is_store | output | 1 | Replayed access kind |
| replay_fmt | output | FMT_W | Replayed size format |
| replay_off | output | OFF_W | Replayed offset |
| replay_reg | output | REG_W | Replayed register |

## Verification
The assertions assume that the cache never presents a merge into an entry that has already left PENDING, and never one beyond the last slot. They also assume that a fill names at most one PENDING block, and that a memory request follows only an accepted primary miss. Together these reduce to the claim that the lookup keeps at most one live entry per block. The stimulus stays inside these assumptions. It removes a miss in the cycle after it is presented and never holds a stalled miss for a retry. It returns each fill once, after its request, apart from one deliberate fill for an untracked block. It drives at most one miss and one fill per cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic [1:0] {
        E_FREE   = 2'd0,
        E_PEND   = 2'd1,
        E_FILLED = 2'd2,
        E_DRAIN  = 2'd3
    } ent_state_e;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_RUN  = 1'b1
    } rep_state_e;

endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
    import mshr_pkg::*;
#(
    parameter int BLK_AW = 26,
    parameter int PW     = 13,
    parameter int N_SLOT = 4,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              merge_i,
    input  logic [BLK_AW-1:0] blk_i,
    input  logic [PW-1:0]     pay_i,
    input  logic              fill_i,
    input  logic              start_i,
    input  logic              done_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output ent_state_e        state_o,
    output logic [BLK_AW-1:0] blk_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [PW-1:0]     rd_pay_o
);

    ent_state_e        state_q, state_d;
    logic [BLK_AW-1:0] blk_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PW-1:0]     slot_q [N_SLOT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_FREE:   if (alloc_i) state_d = E_PEND;
            E_PEND:   if (fill_i)  state_d = E_FILLED;
            E_FILLED: if (start_i) state_d = E_DRAIN;
            E_DRAIN:  if (done_i)  state_d = E_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            cnt_q <= '0;
        end else if (alloc_i) begin
            blk_q <= blk_i;
            cnt_q <= CNT_W'(1);
        end else if (merge_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_i) begin
            slot_q[0] <= pay_i;
        end else if (merge_i) begin
            slot_q[IDX_W'(cnt_q)] <= pay_i;
        end
    end

    assign state_o  = state_q;
    assign blk_o    = blk_q;
    assign cnt_o    = cnt_q;
    assign rd_pay_o = slot_q[rd_idx_i];

    // R2: allocation only lands on a free entry
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == E_FREE);

    // R3: merges go only into an entry still waiting for its fill
    p_merge_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> state_q == E_PEND);

    // R5: a merge never goes past the last slot
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> cnt_q < CNT_W'(N_SLOT));

    // R7: the replay engine finishes only an entry it is draining
    p_done_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> state_q == E_DRAIN);

endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
    parameter int N_ENT  = 4,
    parameter int BLK_AW = 26,
    parameter int N_SLOT = 4,
    parameter int CNT_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         miss_valid,
    input  logic [BLK_AW-1:0]            miss_blk,
    input  logic                         fill_valid,
    input  logic [BLK_AW-1:0]            fill_blk,
    input  logic [N_ENT-1:0]             free_vec,
    input  logic [N_ENT-1:0]             pend_vec,
    input  logic [N_ENT-1:0]             busy_vec,
    input  logic [N_ENT-1:0][BLK_AW-1:0] blk_arr,
    input  logic [N_ENT-1:0][CNT_W-1:0]  cnt_arr,
    output logic [N_ENT-1:0]             alloc_vec,
    output logic [N_ENT-1:0]             merge_vec,
    output logic [N_ENT-1:0]             fill_vec,
    output logic                         stall
);

    logic [N_ENT-1:0] hit_pend, hit_busy, full_vec, low_free;
    logic             any_hit, any_free;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_pend[i] = pend_vec[i] && (blk_arr[i] == miss_blk);
        assign hit_busy[i] = busy_vec[i] && (blk_arr[i] == miss_blk);
        assign full_vec[i] = (cnt_arr[i] == CNT_W'(N_SLOT));
        assign fill_vec[i] = fill_valid && pend_vec[i] && (blk_arr[i] == fill_blk);
    end

    assign any_hit  = |(hit_pend | hit_busy);
    assign any_free = |free_vec;
    assign low_free = free_vec & (~free_vec + N_ENT'(1));

    always_comb begin
        stall = 1'b0;
        if (miss_valid) begin
            if (|hit_busy)                    stall = 1'b1;
            else if (|(hit_pend & full_vec))  stall = 1'b1;
            else if (!any_hit && !any_free)   stall = 1'b1;
        end
    end

    assign merge_vec = (miss_valid && !stall) ? hit_pend : '0;
    assign alloc_vec = (miss_valid && !stall && !any_hit) ? low_free : '0;

    // R3: one live entry per block at most
    p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_pend | hit_busy) <= 1);

    // R8: a fill names at most one waiting entry
    p_fill_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fill_vec) <= 1);

endmodule

// File: rtl/mshr_replay.sv
module mshr_replay
    import mshr_pkg::*;
#(
    parameter int N_ENT = 4,
    parameter int CNT_W = 3,
    parameter int IDX_W = 2,
    parameter int EW    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_ENT-1:0]            filled_vec,
    input  logic [N_ENT-1:0][CNT_W-1:0] cnt_arr,
    output logic [N_ENT-1:0]            start_vec,
    output logic [N_ENT-1:0]            done_vec,
    output logic [EW-1:0]               sel_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic                        valid_o
);

    rep_state_e       state_q, state_d;
    logic [EW-1:0]    sel_q, pick;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cur_cnt;
    logic             is_last, pick_any;

    always_comb begin
        pick = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (filled_vec[i]) pick = EW'(i);
        end
    end

    assign pick_any = |filled_vec;
    assign cur_cnt  = cnt_arr[sel_q];
    assign is_last  = (CNT_W'(idx_q) + CNT_W'(1)) == cur_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        start_vec = '0;
        done_vec  = '0;
        valid_o   = 1'b0;
        unique case (state_q)
            R_IDLE: begin
                if (pick_any) begin
                    start_vec[pick] = 1'b1;
                    state_d         = R_RUN;
                end
            end
            R_RUN: begin
                valid_o = 1'b1;
                if (is_last) begin
                    done_vec[sel_q] = 1'b1;
                    state_d         = R_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            idx_q <= '0;
        end else if (state_q == R_IDLE && pick_any) begin
            sel_q <= pick;
            idx_q <= '0;
        end else if (state_q == R_RUN && !is_last) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign sel_o = sel_q;
    assign idx_o = idx_q;

    // R7: a running replay always has at least one stored slot to present
    p_run_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == R_RUN |-> cur_cnt != '0);

endmodule

// File: rtl/mshr_file.sv
module mshr_file
    import mshr_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int N_SLOT = 4,
    parameter int BLK_AW = 26,
    parameter int OFF_W  = 4,
    parameter int FMT_W  = 3,
    parameter int REG_W  = 5,
    localparam int EW    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
    localparam int CNT_W = $clog2(N_SLOT + 1),
    localparam int PW    = 1 + FMT_W + OFF_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [BLK_AW-1:0] miss_blk,
    input  logic              miss_is_store,
    input  logic [FMT_W-1:0]  miss_fmt,
    input  logic [OFF_W-1:0]  miss_off,
    input  logic [REG_W-1:0]  miss_reg,
    output logic              miss_stall,
    output logic              mem_req_valid,
    output logic [BLK_AW-1:0] mem_req_blk,
    input  logic              fill_valid,
    input  logic [BLK_AW-1:0] fill_blk,
    output logic              replay_valid,
    output logic [EW-1:0]     replay_entry,
    output logic [BLK_AW-1:0] replay_blk,
    output logic              replay_is_store,
    output logic [FMT_W-1:0]  replay_fmt,
    output logic [OFF_W-1:0]  replay_off,
    output logic [REG_W-1:0]  replay_reg
);

    ent_state_e                   ent_st [N_ENT];
    logic [N_ENT-1:0][BLK_AW-1:0] blk_arr;
    logic [N_ENT-1:0][CNT_W-1:0]  cnt_arr;
    logic [N_ENT-1:0][PW-1:0]     pay_arr;
    logic [N_ENT-1:0]             free_vec, pend_vec, filled_vec, drain_vec, busy_vec;
    logic [N_ENT-1:0]             alloc_vec, merge_vec, fill_vec, start_vec, done_vec;
    logic [EW-1:0]                rep_sel;
    logic [IDX_W-1:0]             rep_idx;
    logic                         rep_valid;
    logic [PW-1:0]                miss_pay;

    assign miss_pay = {miss_is_store, miss_fmt, miss_off, miss_reg};

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        mshr_entry #(
            .BLK_AW (BLK_AW),
            .PW     (PW),
            .N_SLOT (N_SLOT),
            .CNT_W  (CNT_W),
            .IDX_W  (IDX_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (alloc_vec[i]),
            .merge_i  (merge_vec[i]),
            .blk_i    (miss_blk),
            .pay_i    (miss_pay),
            .fill_i   (fill_vec[i]),
            .start_i  (start_vec[i]),
            .done_i   (done_vec[i]),
            .rd_idx_i (rep_idx),
            .state_o  (ent_st[i]),
            .blk_o    (blk_arr[i]),
            .cnt_o    (cnt_arr[i]),
            .rd_pay_o (pay_arr[i])
        );
        assign free_vec[i]   = (ent_st[i] == E_FREE);
        assign pend_vec[i]   = (ent_st[i] == E_PEND);
        assign filled_vec[i] = (ent_st[i] == E_FILLED);
        assign drain_vec[i]  = (ent_st[i] == E_DRAIN);
    end

    assign busy_vec = filled_vec | drain_vec;

    mshr_lookup #(
        .N_ENT  (N_ENT),
        .BLK_AW (BLK_AW),
        .N_SLOT (N_SLOT),
        .CNT_W  (CNT_W)
    ) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_blk   (miss_blk),
        .fill_valid (fill_valid),
        .fill_blk   (fill_blk),
        .free_vec   (free_vec),
        .pend_vec   (pend_vec),
        .busy_vec   (busy_vec),
        .blk_arr    (blk_arr),
        .cnt_arr    (cnt_arr),
        .alloc_vec  (alloc_vec),
        .merge_vec  (merge_vec),
        .fill_vec   (fill_vec),
        .stall      (miss_stall)
    );

    mshr_replay #(
        .N_ENT (N_ENT),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .EW    (EW)
    ) u_replay (
        .clk        (clk),
        .rst_n      (rst_n),
        .filled_vec (filled_vec),
        .cnt_arr    (cnt_arr),
        .start_vec  (start_vec),
        .done_vec   (done_vec),
        .sel_o      (rep_sel),
        .idx_o      (rep_idx),
        .valid_o    (rep_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_blk   <= '0;
        end else begin
            mem_req_valid <= |alloc_vec;
            if (|alloc_vec) mem_req_blk <= miss_blk;
        end
    end

    assign replay_valid = rep_valid;
    assign replay_entry = rep_sel;
    assign replay_blk   = blk_arr[rep_sel];
    assign {replay_is_store, replay_fmt, replay_off, replay_reg} = pay_arr[rep_sel];

    // R2: a fetch is raised only after an accepted miss
    p_req_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(miss_valid && !miss_stall));

    // R4: a stalled miss never produces a fetch
    p_no_req_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_stall) |=> !mem_req_valid);

    // R10: only one entry drains at a time
    p_single_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drain_vec));

    // R7: the replayed entry is the one in its draining state
    p_replay_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> drain_vec[rep_sel]);

endmodule

// File: tb/mshr_file_test.sv
`timescale 1ns/1ps
module mshr_file_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [25:0] miss_blk;
    logic        miss_is_store;
    logic [2:0]  miss_fmt;
    logic [3:0]  miss_off;
    logic [4:0]  miss_reg;
    logic        miss_stall;
    logic        mem_req_valid;
    logic [25:0] mem_req_blk;
    logic        fill_valid;
    logic [25:0] fill_blk;
    logic        replay_valid;
    logic [1:0]  replay_entry;
    logic [25:0] replay_blk;
    logic        replay_is_store;
    logic [2:0]  replay_fmt;
    logic [3:0]  replay_off;
    logic [4:0]  replay_reg;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [25:0] BA = 26'h00000A1;
    localparam logic [25:0] BB = 26'h00000B2;
    localparam logic [25:0] BC = 26'h00000C3;
    localparam logic [25:0] BD = 26'h00000D4;
    localparam logic [25:0] BE = 26'h00000E5;
    localparam logic [25:0] BZ = 26'h3FFFF00;

    always #2.5 clk = ~clk;

    mshr_file uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .miss_valid      (miss_valid),
        .miss_blk        (miss_blk),
        .miss_is_store   (miss_is_store),
        .miss_fmt        (miss_fmt),
        .miss_off        (miss_off),
        .miss_reg        (miss_reg),
        .miss_stall      (miss_stall),
        .mem_req_valid   (mem_req_valid),
        .mem_req_blk     (mem_req_blk),
        .fill_valid      (fill_valid),
        .fill_blk        (fill_blk),
        .replay_valid    (replay_valid),
        .replay_entry    (replay_entry),
        .replay_blk      (replay_blk),
        .replay_is_store (replay_is_store),
        .replay_fmt      (replay_fmt),
        .replay_off      (replay_off),
        .replay_reg      (replay_reg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Called at a negedge: compares the replay port with the expected access.
    task automatic exp_rep(input bit v, input logic [1:0] ent, input logic [25:0] b,
                           input bit st, input logic [2:0] f, input logic [3:0] o,
                           input logic [4:0] r, input string req);
        longint act_w, exp_w;
        chk(replay_valid == v, req, "replay_valid", replay_valid, v);
        if (v) begin
            act_w = {replay_entry, replay_blk, replay_is_store, replay_fmt, replay_off, replay_reg};
            exp_w = {ent, b, st, f, o, r};
            chk(act_w == exp_w, req, "replay fields", act_w, exp_w);
        end
    endtask

    task automatic do_miss(input logic [25:0] b, input bit st, input logic [2:0] f,
                           input logic [3:0] o, input logic [4:0] r,
                           input bit exp_stall, input bit exp_req, input string req);
        @(negedge clk);
        miss_valid = 1'b1; miss_blk = b; miss_is_store = st;
        miss_fmt = f; miss_off = o; miss_reg = r;
        #0.5;
        chk(miss_stall == exp_stall, req, "miss_stall", miss_stall, exp_stall);
        @(negedge clk);
        chk(mem_req_valid == exp_req, req, "mem_req_valid", mem_req_valid, exp_req);
        if (exp_req) chk(mem_req_blk == b, req, "mem_req_blk", mem_req_blk, b);
        miss_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; miss_valid = 1'b0; miss_blk = '0; miss_is_store = 1'b0;
        miss_fmt = '0; miss_off = '0; miss_reg = '0; fill_valid = 1'b0; fill_blk = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        chk(replay_valid == 1'b0, "R1", "replay_valid", replay_valid, 0);
        chk(miss_stall == 1'b0, "R1", "miss_stall", miss_stall, 0);
    endtask

    task automatic t_fill_a_block();
        // R2/R1: primary miss, then R3 merges, then R5 full entry
        do_miss(BA, 0, 3'd2, 4'd3, 5'd7, 0, 1, "R2");
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R2", "single request pulse", mem_req_valid, 0);
        do_miss(BA, 1, 3'd1, 4'd8, 5'd12, 0, 0, "R3");
        do_miss(BA, 0, 3'd0, 4'd15, 5'd1, 0, 0, "R3");
        do_miss(BA, 1, 3'd3, 4'd0, 5'd31, 0, 0, "R3");
        do_miss(BA, 0, 3'd4, 4'd4, 5'd20, 1, 0, "R5");
    endtask

    task automatic t_full_file();
        do_miss(BB, 0, 3'd2, 4'd1, 5'd2, 0, 1, "R2");
        do_miss(BC, 0, 3'd2, 4'd4, 5'd5, 0, 1, "R2");
        do_miss(BD, 1, 3'd3, 4'd9, 5'd6, 0, 1, "R2");
        do_miss(BE, 0, 3'd1, 4'd2, 5'd3, 1, 0, "R4");
    endtask

    task automatic t_stray_fill();
        @(negedge clk);
        fill_valid = 1'b1; fill_blk = BZ;
        @(negedge clk);
        fill_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            exp_rep(0, 0, 0, 0, 0, 0, 0, "R8");
            @(negedge clk);
        end
    endtask

    task automatic t_drain_a();
        @(negedge clk);
        fill_valid = 1'b1; fill_blk = BA;
        @(negedge clk);
        fill_valid = 1'b0;
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R7");
        miss_valid = 1'b1; miss_blk = BA; miss_is_store = 1'b0;
        miss_fmt = 3'd2; miss_off = 4'd6; miss_reg = 5'd8;
        #0.5;
        chk(miss_stall == 1'b1, "R6", "miss_stall on filled", miss_stall, 1);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(mem_req_valid == 1'b0, "R6", "mem_req_valid", mem_req_valid, 0);
        exp_rep(1, 2'd0, BA, 0, 3'd2, 4'd3, 5'd7, "R7");
        @(negedge clk);
        exp_rep(1, 2'd0, BA, 1, 3'd1, 4'd8, 5'd12, "R7");
        @(negedge clk);
        exp_rep(1, 2'd0, BA, 0, 3'd0, 4'd15, 5'd1, "R7");
        @(negedge clk);
        exp_rep(1, 2'd0, BA, 1, 3'd3, 4'd0, 5'd31, "R7");
        @(negedge clk);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R7");
        // freed entry 0 is reused with a fresh fetch
        do_miss(BA, 0, 3'd2, 4'd5, 5'd9, 0, 1, "R7");
    endtask

    task automatic t_order_entries();
        do_miss(BC, 1, 3'd1, 4'd6, 5'd3, 0, 0, "R3");
        @(negedge clk);
        fill_valid = 1'b1; fill_blk = BC;
        @(negedge clk);
        fill_blk = BD;
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        fill_blk = BB;
        exp_rep(1, 2'd2, BC, 0, 3'd2, 4'd4, 5'd5, "R10");
        @(negedge clk);
        fill_valid = 1'b0;
        exp_rep(1, 2'd2, BC, 1, 3'd1, 4'd6, 5'd3, "R10");
        @(negedge clk);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        exp_rep(1, 2'd1, BB, 0, 3'd2, 4'd1, 5'd2, "R10");
        @(negedge clk);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        exp_rep(1, 2'd3, BD, 1, 3'd3, 4'd9, 5'd6, "R10");
        @(negedge clk);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R10");
    endtask

    task automatic t_merge_with_fill();
        @(negedge clk);
        fill_valid = 1'b1; fill_blk = BA;
        miss_valid = 1'b1; miss_blk = BA; miss_is_store = 1'b1;
        miss_fmt = 3'd0; miss_off = 4'd2; miss_reg = 5'd4;
        #0.5;
        chk(miss_stall == 1'b0, "R9", "miss_stall", miss_stall, 0);
        @(negedge clk);
        fill_valid = 1'b0; miss_valid = 1'b0;
        chk(mem_req_valid == 1'b0, "R9", "mem_req_valid", mem_req_valid, 0);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        exp_rep(1, 2'd0, BA, 0, 3'd2, 4'd5, 5'd9, "R9");
        @(negedge clk);
        exp_rep(1, 2'd0, BA, 1, 3'd0, 4'd2, 5'd4, "R9");
        @(negedge clk);
        exp_rep(0, 0, 0, 0, 0, 0, 0, "R9");
        // all entries free again: a new block takes entry 0
        do_miss(BE, 0, 3'd1, 4'd2, 5'd3, 0, 1, "R2");
        @(negedge clk);
        fill_valid = 1'b1; fill_blk = BE;
        @(negedge clk);
        fill_valid = 1'b0;
        @(negedge clk);
        exp_rep(1, 2'd0, BE, 0, 3'd1, 4'd2, 5'd3, "R2");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        t_reset();
        t_fill_a_block();
        t_full_file();
        t_stray_fill();
        t_drain_a();
        t_order_entries();
        t_merge_with_fill();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule